// File: doc/BRIEF.md
# Power-of-Two Clock Output Divider

This block derives a slow clock for an output pin from one of three selectable input clocks. The chosen input clock is presented to the block as a strobe. Each strobe pulse, sampled on the block clock, counts as one input edge. A cascade of divide-by-two stages counts those edges. A tap selector picks one stage to drive the output, so the output runs at the input rate divided by 2^(N+1), where N is the 4-bit tap number.

A level enable starts and stops the divider. When the enable is raised, the cascade starts from zero, so the output begins low. When it is dropped, the output is never cut short while it is high. The cascade keeps counting until the output falls, and after that the output is held low. If the tap number changes while the divider is running, the new number waits for the next falling edge of the output, and the cascade then restarts from zero. The output therefore never shows a shortened pulse.

Top module: `cko_divider`

## Requirements
- R1: After reset, and while the enable has never been raised, `clk_out` is low regardless of the strobes.
- R2: While running with a steady tap number N (0 to 15), `clk_out` is stage N of a 16-stage binary count of the selected strobes. Its period is therefore 2^(N+1) strobes, with 2^N strobes high and 2^N strobes low.
- R3: Raising the enable from the stopped state clears the count. `clk_out` is low in the cycle after the enable is sampled, and it first rises after exactly 2^N selected strobes, even if a count was left over from an earlier run.
- R4: Source code 2'b00 selects `xtal_tick`, 2'b10 selects `hclk_tick` and 2'b11 selects `hirc_tick`. Strobes on the two unselected inputs do not change the output.
- R5: Source code 2'b01 selects no clock. `clk_out` is low while it is applied, and the count stays frozen, so returning to a valid code resumes the same output level.
- R6: If the enable is dropped while `clk_out` is high, counting continues until `clk_out` falls. From then on `clk_out` stays low.
- R7: If the enable is dropped while `clk_out` is low, `clk_out` stays low and no further pulse appears.
- R8: A new tap number requested while running takes effect only at the falling edge of the current output. At that edge the count restarts from zero, so the new setting begins with a full low phase of 2^Nnew strobes.
- R9: If the enable is raised again before a pending stop completes, the divider continues without restarting its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| div_en | input | 1 | Divider enable (level) |
| tap_sel | input | 4 | Tap number N; output = input / 2^(N+1) |
| src_sel | input | 2 | Source code: 00 crystal, 01 none, 10 bus clock, 11 internal RC |
| xtal_tick | input | 1 | One-cycle strobe per edge of the external crystal clock |
| hclk_tick | input | 1 | One-cycle strobe per edge of the bus clock |
| hirc_tick | input | 1 | One-cycle strobe per edge of the internal RC clock |
| clk_out | output | 1 | Divided clock for the output pin |

## Verification
The clean-stop drain and the deferred tap change both act on the same falling edge of the output. This happens when the enable is dropped while the output is high and a different tap number is pending at the same time. The bench sets up this case by lowering the enable and changing the tap number together in the middle of a high phase. It then expects the output to stay high until exactly the strobe that completes the high phase, to fall on that strobe, and to stay low for every later strobe. In that cycle the adopted tap restarts the count, and this must not start a new pulse.

// File: rtl/cko_pkg.sv
// Shared types for the clock output divider.
package cko_pkg;
    // Source selector codes; the values are the pin-level encoding of src_sel.
    typedef enum logic [1:0] {
        SRC_XTAL = 2'b00,
        SRC_NONE = 2'b01,
        SRC_HCLK = 2'b10,
        SRC_HIRC = 2'b11
    } cko_src_e;
endpackage

// File: rtl/cko_src_pick.sv
// Source picker: forwards the strobe of the selected input clock.
// Assumes each strobe is a single-cycle pulse per input-clock edge, already
// synchronous to clk. The reserved code yields no strobe and flags itself.
module cko_src_pick
    import cko_pkg::*;
(
    input  logic [1:0] src_sel,
    input  logic       xtal_tick,
    input  logic       hclk_tick,
    input  logic       hirc_tick,
    output logic       tick,
    output logic       live
);
    // Decode the selector into a strobe and a "valid source" flag.
    always_comb begin
        tick = 1'b0;
        live = 1'b1;
        case (cko_src_e'(src_sel))
            SRC_XTAL: tick = xtal_tick;
            SRC_HCLK: tick = hclk_tick;
            SRC_HIRC: tick = hirc_tick;
            default:  live = 1'b0;
        endcase
    end
endmodule

// File: rtl/cko_stage_chain.sv
// Cascade of divide-by-two stages. Stage i toggles on an advance when all
// lower stages are one, so the vector counts advances in binary.
// Assumes clear and adv are not asserted in the same cycle (clear wins).
module cko_stage_chain #(
    parameter int STAGES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              adv,
    output logic [STAGES-1:0] stage
);
    logic [STAGES-1:0] carry;

    assign carry[0] = adv;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic stage_q;

        if (i > 0) begin : g_carry
            assign carry[i] = carry[i-1] & stage[i-1];
        end

        // One toggle flop per stage, toggled by the ripple of lower stages.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                stage_q <= 1'b0;
            end else if (carry[i]) begin
                stage_q <= ~stage_q;
            end
        end

        assign stage[i] = stage_q;
    end
endmodule

// File: rtl/cko_ctrl.sv
// Run control and tap selection. It starts the cascade from zero, drains it
// on disable until the output is low, and adopts a new tap only at the
// falling edge of the current output. Assumes STAGES is a power of two.
module cko_ctrl #(
    parameter int STAGES = 16,
    parameter int SEL_W  = $clog2(STAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [SEL_W-1:0]  n_req,
    input  logic              tick,
    input  logic              live,
    input  logic [STAGES-1:0] stage,
    output logic              running,
    output logic [SEL_W-1:0]  n_act,
    output logic              clear,
    output logic              adv,
    output logic              clk_out
);
    logic low_ones;
    logic fall;
    logic start;
    logic stop;
    logic adopt;

    // Output: the active tap, forced low when stopped or without a source.
    assign clk_out = running & live & stage[n_act];

    // All stages up to and including the tap are one: next advance falls.
    always_comb begin
        low_ones = 1'b1;
        for (int i = 0; i < STAGES; i++) begin
            if (i <= int'(n_act)) begin
                low_ones = low_ones & stage[i];
            end
        end
    end

    assign fall  = tick & low_ones;
    assign start = ~running & en;
    assign stop  = running & ~en & ~clk_out;
    assign adopt = running & ~stop & fall & (n_req != n_act);
    assign clear = start | adopt;
    assign adv   = running & ~stop & tick & ~adopt;

    // Run flag: set on enable from idle, cleared once drained to low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
        end else if (start) begin
            running <= 1'b1;
        end else if (stop) begin
            running <= 1'b0;
        end
    end

    // Active tap: loaded at start or at a falling edge with a new request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_act <= '0;
        end else if (start || adopt) begin
            n_act <= n_req;
        end
    end
endmodule

// File: rtl/cko_divider.sv
// Power-of-two clock output divider top. Wires the source picker, the
// stage cascade and the run control together. All strobes are sampled
// on clk; clk_out is a function of registered state and src_sel.
module cko_divider #(
    parameter int STAGES = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       div_en,
    input  logic [$clog2(STAGES)-1:0]  tap_sel,
    input  logic [1:0]                 src_sel,
    input  logic                       xtal_tick,
    input  logic                       hclk_tick,
    input  logic                       hirc_tick,
    output logic                       clk_out
);
    localparam int SEL_W = $clog2(STAGES);

    logic              tick;
    logic              live;
    logic              clear;
    logic              adv;
    logic              running;
    logic [SEL_W-1:0]  n_act;
    logic [STAGES-1:0] stage;

    cko_src_pick u_pick (
        .src_sel   (src_sel),
        .xtal_tick (xtal_tick),
        .hclk_tick (hclk_tick),
        .hirc_tick (hirc_tick),
        .tick      (tick),
        .live      (live)
    );

    cko_stage_chain #(.STAGES(STAGES)) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .adv   (adv),
        .stage (stage)
    );

    cko_ctrl #(.STAGES(STAGES), .SEL_W(SEL_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (div_en),
        .n_req   (tap_sel),
        .tick    (tick),
        .live    (live),
        .stage   (stage),
        .running (running),
        .n_act   (n_act),
        .clear   (clear),
        .adv     (adv),
        .clk_out (clk_out)
    );
endmodule

// File: rtl/cko_divider_chk.sv
// Property checker for the clock output divider, bound to the top module.
module cko_divider_chk #(
    parameter int SEL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             div_en,
    input logic [1:0]       src_sel,
    input logic             clk_out,
    input logic             running,
    input logic [SEL_W-1:0] n_act
);
    // R3: a fresh start always begins with the output low.
    a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> !clk_out);

    // R5: the reserved source code never lets the output high.
    a_r5_reserved_low: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 2'b01) |-> !clk_out);

    // R7: once disabled and low, the output stays low.
    a_r7_held_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!div_en && !clk_out) |=> !clk_out);

    // R8: a tap switch only happens with the output low.
    a_r8_tap_swap_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(n_act) |-> !clk_out);
endmodule

bind cko_divider cko_divider_chk #(.SEL_W(SEL_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_en  (div_en),
    .src_sel (src_sel),
    .clk_out (clk_out),
    .running (running),
    .n_act   (n_act)
);

// File: tb/cko_divider_tb.sv
// Directed bench for the clock output divider.
module cko_divider_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       div_en = 1'b0;
    logic [3:0] tap_sel = 4'd0;
    logic [1:0] src_sel = 2'b10;
    logic       xtal_tick = 1'b0;
    logic       hclk_tick = 1'b0;
    logic       hirc_tick = 1'b0;
    logic       clk_out;

    int checks = 0;
    int errors = 0;

    logic [31:0] mticks;
    int          m_n;
    bit          stopped;

    cko_divider u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_en    (div_en),
        .tap_sel   (tap_sel),
        .src_sel   (src_sel),
        .xtal_tick (xtal_tick),
        .hclk_tick (hclk_tick),
        .hirc_tick (hirc_tick),
        .clk_out   (clk_out)
    );

    always #10 clk = ~clk;

    // Inputs change at the falling edge; outputs are sampled at the next one.
    task automatic drive(input logic x, input logic h, input logic r);
        xtal_tick = x;
        hclk_tick = h;
        hirc_tick = r;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input logic exp, input string req, input string what);
        checks++;
        if (clk_out !== exp) begin
            errors++;
            $display("FAIL %s %s: clk_out=%b expected %b", req, what, clk_out, exp);
        end
    endtask

    function automatic logic model_out();
        logic v;
        v = 1'b0;
        if (!stopped) begin
            v = mticks[m_n];
        end
        return v;
    endfunction

    // Reference count of selected strobes, with tap adoption at falling edges.
    task automatic model_tick();
        logic [31:0] nxt;
        nxt = mticks + 1;
        if (mticks[m_n] && !nxt[m_n] && int'(tap_sel) != m_n) begin
            mticks = 0;
            m_n    = int'(tap_sel);
        end else begin
            mticks = nxt;
        end
    endtask

    // One cycle of stimulus plus model update and comparison.
    task automatic step(input logic x, input logic h, input logic r, input string req);
        logic t;
        if (!div_en && model_out() == 1'b0) begin
            stopped = 1;
        end
        drive(x, h, r);
        case (src_sel)
            2'b00:   t = x;
            2'b10:   t = h;
            2'b11:   t = r;
            default: t = 1'b0;
        endcase
        if (!stopped && t) begin
            model_tick();
        end
        check(model_out(), req, $sformatf("strobe %0d tap %0d", mticks, m_n));
    endtask

    task automatic do_reset();
        rst_n  = 1'b0;
        div_en = 1'b0;
        drive(0, 0, 0);
        drive(0, 0, 0);
        rst_n = 1'b1;
    endtask

    task automatic start(input logic [3:0] n, input logic [1:0] s);
        tap_sel = n;
        src_sel = s;
        div_en  = 1'b1;
        drive(1, 1, 1);
        mticks  = 0;
        m_n     = int'(n);
        stopped = 0;
        check(1'b0, "R3", "low right after start");
    endtask

    task automatic run_hclk_to(input int target, input string req);
        while (mticks != 32'(target)) begin
            step(0, 1, 0, req);
        end
    endtask

    task automatic t_reset();
        do_reset();
        check(1'b0, "R1", "after reset");
        for (int i = 0; i < 8; i++) begin
            drive(1, 1, 1);
            check(1'b0, "R1", "idle with strobes");
        end
    endtask

    task automatic t_ratios();
        do_reset();
        start(4'd0, 2'b10);
        for (int i = 0; i < 20; i++) step(0, 1, 0, "R2");
        do_reset();
        start(4'd3, 2'b00);
        for (int i = 0; i < 120; i++) step(i % 3 == 0, 1, i % 5 == 0, "R4");
        do_reset();
        start(4'd2, 2'b11);
        for (int i = 0; i < 90; i++) step(1, i % 2 == 0, i % 3 == 0, "R4");
    endtask

    task automatic t_top_stage();
        do_reset();
        start(4'd15, 2'b10);
        for (int i = 1; i <= 32768; i++) begin
            drive(0, 1, 0);
            if (i == 32767) check(1'b0, "R2", "top stage before 2^15");
            if (i == 32768) check(1'b1, "R2", "top stage at 2^15");
        end
    endtask

    task automatic t_reserved();
        do_reset();
        start(4'd1, 2'b10);
        run_hclk_to(2, "R2");
        check(1'b1, "R5", "high before reserved code");
        src_sel = 2'b01;
        for (int i = 0; i < 4; i++) begin
            drive(1, 1, 1);
            check(1'b0, "R5", "reserved code");
        end
        src_sel = 2'b10;
        drive(0, 0, 0);
        check(1'b1, "R5", "count frozen while reserved");
    endtask

    task automatic t_stop_high();
        do_reset();
        start(4'd2, 2'b10);
        run_hclk_to(5, "R2");
        div_en  = 1'b0;
        tap_sel = 4'd0;
        for (int i = 0; i < 14; i++) step(0, 1, 0, "R6");
    endtask

    task automatic t_stop_low_restart();
        do_reset();
        start(4'd3, 2'b10);
        run_hclk_to(3, "R2");
        div_en = 1'b0;
        for (int i = 0; i < 30; i++) begin
            drive(1, 1, 1);
            check(1'b0, "R7", "disabled while low");
        end
        start(4'd3, 2'b10);
        for (int i = 0; i < 24; i++) step(0, 1, 0, "R3");
    endtask

    task automatic t_reenable();
        do_reset();
        start(4'd2, 2'b10);
        run_hclk_to(5, "R2");
        div_en = 1'b0;
        step(0, 1, 0, "R9");
        div_en = 1'b1;
        for (int i = 0; i < 20; i++) step(0, 1, 0, "R9");
    endtask

    task automatic t_tap_change();
        do_reset();
        start(4'd1, 2'b10);
        run_hclk_to(2, "R2");
        tap_sel = 4'd3;
        for (int i = 0; i < 40; i++) step(0, 1, 0, "R8");
        do_reset();
        start(4'd3, 2'b10);
        run_hclk_to(1, "R2");
        tap_sel = 4'd0;
        for (int i = 0; i < 20; i++) step(0, 1, 0, "R8");
    endtask

    initial begin
        mticks  = 0;
        m_n     = 0;
        stopped = 1;
        @(negedge clk);
        t_reset();
        t_ratios();
        t_top_stage();
        t_reserved();
        t_stop_high();
        t_stop_low_restart();
        t_reenable();
        t_tap_change();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule